// File: doc/BRIEF.md
# Register Dependency Scoreboard

This block guards instruction issue in a front end that sends several instructions into flight at once and lets them finish in any order. It holds a pending-write flag for each of 32 integer and 32 floating-point registers. Each cycle the front end presents one issue request. The request carries a mask of source registers, a mask of destination registers and an instruction kind. The scoreboard answers at once, in the same cycle, whether the request may go. When a request is granted, its destination flags are raised at the next clock edge. A completion port lowers the flags of an instruction that has finished.

Beyond data hazards, the block enforces control holds. There is no prediction and no flush. A granted branch therefore stops all further issue until the branch reports completion. A register-window change waits until no instruction is in flight. Once such a change has been requested, nothing else may slip in ahead of it. While the change is in flight, nothing may follow it. An in-flight counter detects the drained condition and also caps the number of outstanding instructions.

The hold logic is a four-state machine:
- **OPEN**: issue is allowed.
- **BRANCH_WAIT**: a branch is in flight.
- **DRAIN**: a window change is waiting for the machine to empty.
- **WINDOW_WAIT**: a window change is in flight.

The transitions are:
- OPEN→BRANCH_WAIT when a branch is granted.
- OPEN→WINDOW_WAIT when a window change is granted.
- OPEN→DRAIN when a window change is requested while instructions are outstanding.
- DRAIN→OPEN when the counter reads zero.
- BRANCH_WAIT→OPEN when a branch completion arrives.
- WINDOW_WAIT→OPEN when a window completion arrives.

Kind encoding on both ports: 0 = plain, 1 = branch, 2 = window change.

Top module: `dep_scoreboard`

## Requirements
- R1: After reset both flag vectors read zero, `ctrl_hold` is low, and a plain request with no sources is granted.
- R2: A granted request's destination bits (integer mask bit i = register i, FP likewise) appear set on `busy_int`/`busy_fp` one cycle after the granting edge.
- R3: Integer register 0 (bit 0 of `busy_int`) never reads busy, even when named as a destination.
- R4: `issue_ok` is low whenever any source bit of the request matches a set flag in the corresponding vector, and high for a plain request whose sources are all clear while the state is OPEN and the counter is below its cap.
- R5: A completion clears its destination bits at the next edge.
- R6: When the same bit is set by a grant and cleared by a completion in the same cycle, it ends up set.
- R7: A request that is not granted changes no flag.
- R8: After a branch (kind 1) is granted, no request of any kind is granted until a completion with kind 1 arrives. Issue reopens in the cycle after that completion edge.
- R9: A window change (kind 2) is refused while any instruction is in flight. Such a refused request moves the block to DRAIN, where every request is refused until the in-flight count has been zero at an edge.
- R10: After a window change is granted, every request is refused until a completion with kind 2 arrives.
- R11: With MAX_INFLIGHT instructions outstanding, every request is refused. One completion makes room again at the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_req | input | 1 | Issue request valid |
| issue_kind | input | 2 | 0 plain, 1 branch, 2 window change |
| issue_src_int | input | 32 | Integer source register mask |
| issue_src_fp | input | 32 | FP source register mask |
| issue_dst_int | input | 32 | Integer destination mask |
| issue_dst_fp | input | 32 | FP destination mask |
| issue_ok | output | 1 | Request granted this cycle (combinational) |
| cmp_valid | input | 1 | Completion report valid |
| cmp_kind | input | 2 | Kind of the completing instruction |
| cmp_dst_int | input | 32 | Integer destinations to release |
| cmp_dst_fp | input | 32 | FP destinations to release |
| busy_int | output | 32 | Integer pending-write flags |
| busy_fp | output | 32 | FP pending-write flags |
| ctrl_hold | output | 1 | Hold state machine is not in OPEN |

## Verification
`issue_ok` is combinational, so the bench reads it in the same cycle it drives a request, a few nanoseconds after the inputs settle. The flag vectors, `ctrl_hold` and the counter each pass through one register, so their effect is read just after the next rising edge. The DRAIN exit is a special case: the counter must first read zero at one edge, and the state moves at the edge after that. The bench therefore waits one extra idle cycle before expecting a window change to be granted. All stimulus changes two nanoseconds after a rising edge, and all reads happen before the following edge.

// File: rtl/dep_sb_pkg.sv
package dep_sb_pkg;
    localparam int NUM_INT_REGS = 32;
    localparam int NUM_FP_REGS  = 32;

    typedef enum logic [1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_BRANCH = 2'd1,
        KIND_WINDOW = 2'd2,
        KIND_RSVD   = 2'd3
    } instr_kind_e;

    typedef enum logic [1:0] {
        ST_OPEN        = 2'd0,
        ST_BRANCH_WAIT = 2'd1,
        ST_DRAIN       = 2'd2,
        ST_WINDOW_WAIT = 2'd3
    } hold_state_e;
endpackage

// File: rtl/dep_sb_busy_bank.sv
module dep_sb_busy_bank #(
    parameter int NREG      = 32,
    parameter bit ZERO_HARD = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] set_mask,
    input  logic [NREG-1:0] clr_mask,
    output logic [NREG-1:0] busy
);
    logic [NREG-1:0] keep_mask;
    logic [NREG-1:0] busy_q;

    generate
        if (ZERO_HARD) begin : g_zero
            assign keep_mask = {{(NREG-1){1'b1}}, 1'b0};
        end else begin : g_all
            assign keep_mask = '1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            // a set in the same cycle overrides a clear
            busy_q <= ((busy_q & ~clr_mask) | set_mask) & keep_mask;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/dep_sb_inflight.sv
module dep_sb_inflight #(
    parameter int MAX_INFLIGHT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic zero,
    output logic full
);
    localparam int CW = $clog2(MAX_INFLIGHT + 1);

    logic [CW-1:0] cnt_q;
    logic          dec_ok;

    assign dec_ok = dec && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec_ok) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (dec_ok && !inc) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign zero = (cnt_q == '0);
    assign full = (cnt_q == CW'(MAX_INFLIGHT));
endmodule

// File: rtl/dep_sb_hold_fsm.sv
module dep_sb_hold_fsm
    import dep_sb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fire,
    input  instr_kind_e fire_kind,
    input  logic        win_waiting,
    input  logic        inflight_zero,
    input  logic        cmp_valid,
    input  instr_kind_e cmp_kind,
    output logic        gate_open,
    output logic        hold
);
    hold_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (fire && fire_kind == KIND_BRANCH)      state_d = ST_BRANCH_WAIT;
                else if (fire && fire_kind == KIND_WINDOW) state_d = ST_WINDOW_WAIT;
                else if (win_waiting && !fire)             state_d = ST_DRAIN;
            end
            ST_BRANCH_WAIT: begin
                if (cmp_valid && cmp_kind == KIND_BRANCH)  state_d = ST_OPEN;
            end
            ST_DRAIN: begin
                if (inflight_zero)                         state_d = ST_OPEN;
            end
            ST_WINDOW_WAIT: begin
                if (cmp_valid && cmp_kind == KIND_WINDOW)  state_d = ST_OPEN;
            end
        endcase
    end

    always_comb begin
        gate_open = (state_q == ST_OPEN);
        hold      = !gate_open;
    end
endmodule

// File: rtl/dep_scoreboard.sv
module dep_scoreboard
    import dep_sb_pkg::*;
#(
    parameter int MAX_INFLIGHT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_req,
    input  logic [1:0]              issue_kind,
    input  logic [NUM_INT_REGS-1:0] issue_src_int,
    input  logic [NUM_FP_REGS-1:0]  issue_src_fp,
    input  logic [NUM_INT_REGS-1:0] issue_dst_int,
    input  logic [NUM_FP_REGS-1:0]  issue_dst_fp,
    output logic                    issue_ok,
    input  logic                    cmp_valid,
    input  logic [1:0]              cmp_kind,
    input  logic [NUM_INT_REGS-1:0] cmp_dst_int,
    input  logic [NUM_FP_REGS-1:0]  cmp_dst_fp,
    output logic [NUM_INT_REGS-1:0] busy_int,
    output logic [NUM_FP_REGS-1:0]  busy_fp,
    output logic                    ctrl_hold
);
    instr_kind_e req_kind, done_kind;
    logic        data_clear, gate_open, inflight_zero, inflight_full;
    logic        fire, win_waiting;

    assign req_kind  = instr_kind_e'(issue_kind);
    assign done_kind = instr_kind_e'(cmp_kind);

    assign data_clear = ((issue_src_int & busy_int) == '0) &&
                        ((issue_src_fp  & busy_fp)  == '0);

    assign issue_ok = issue_req && gate_open && data_clear && !inflight_full &&
                      (req_kind != KIND_WINDOW || inflight_zero);
    assign fire        = issue_ok;
    assign win_waiting = issue_req && req_kind == KIND_WINDOW;

    dep_sb_busy_bank #(.NREG(NUM_INT_REGS), .ZERO_HARD(1'b1)) u_int_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (fire ? issue_dst_int : '0),
        .clr_mask (cmp_valid ? cmp_dst_int : '0),
        .busy     (busy_int)
    );

    dep_sb_busy_bank #(.NREG(NUM_FP_REGS), .ZERO_HARD(1'b0)) u_fp_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (fire ? issue_dst_fp : '0),
        .clr_mask (cmp_valid ? cmp_dst_fp : '0),
        .busy     (busy_fp)
    );

    dep_sb_inflight #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_inflight (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fire),
        .dec   (cmp_valid),
        .zero  (inflight_zero),
        .full  (inflight_full)
    );

    dep_sb_hold_fsm u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire          (fire),
        .fire_kind     (req_kind),
        .win_waiting   (win_waiting),
        .inflight_zero (inflight_zero),
        .cmp_valid     (cmp_valid),
        .cmp_kind      (done_kind),
        .gate_open     (gate_open),
        .hold          (ctrl_hold)
    );
endmodule

// File: rtl/dep_scoreboard_chk.sv
module dep_scoreboard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_req,
    input logic [1:0]  issue_kind,
    input logic [31:0] issue_src_int,
    input logic [31:0] issue_src_fp,
    input logic [31:0] issue_dst_int,
    input logic [31:0] issue_dst_fp,
    input logic        issue_ok,
    input logic        cmp_valid,
    input logic [31:0] cmp_dst_int,
    input logic [31:0] cmp_dst_fp,
    input logic [31:0] busy_int,
    input logic [31:0] busy_fp,
    input logic        ctrl_hold,
    input logic        inflight_zero
);
    p_zero_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_int[0]);

    p_set_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |=> ((busy_int | 32'h1) & $past(issue_dst_int)) == ($past(issue_dst_int) | 32'h0) ||
                     (((busy_int | 32'h1) & $past(issue_dst_int)) == $past(issue_dst_int)));

    p_set_fp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |=> (busy_fp & $past(issue_dst_fp)) == $past(issue_dst_fp));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !issue_ok) |=>
            ((busy_int & $past(cmp_dst_int)) == '0) && ((busy_fp & $past(cmp_dst_fp)) == '0));

    p_src_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> ((issue_src_int & busy_int) == '0) && ((issue_src_fp & busy_fp) == '0));

    p_grant_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> issue_req);

    p_branch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && issue_kind == 2'd1) |=> !issue_ok);

    p_window_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && issue_kind == 2'd2) |-> inflight_zero);

    p_hold_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hold |-> !issue_ok);
endmodule

bind dep_scoreboard dep_scoreboard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_req     (issue_req),
    .issue_kind    (issue_kind),
    .issue_src_int (issue_src_int),
    .issue_src_fp  (issue_src_fp),
    .issue_dst_int (issue_dst_int),
    .issue_dst_fp  (issue_dst_fp),
    .issue_ok      (issue_ok),
    .cmp_valid     (cmp_valid),
    .cmp_dst_int   (cmp_dst_int),
    .cmp_dst_fp    (cmp_dst_fp),
    .busy_int      (busy_int),
    .busy_fp       (busy_fp),
    .ctrl_hold     (ctrl_hold),
    .inflight_zero (inflight_zero)
);

// File: tb/dep_scoreboard_tb.sv
module dep_scoreboard_tb;
    localparam int CAP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_req = 1'b0;
    logic [1:0]  issue_kind = 2'd0;
    logic [31:0] issue_src_int = '0, issue_src_fp = '0;
    logic [31:0] issue_dst_int = '0, issue_dst_fp = '0;
    logic        issue_ok;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_kind = 2'd0;
    logic [31:0] cmp_dst_int = '0, cmp_dst_fp = '0;
    logic [31:0] busy_int, busy_fp;
    logic        ctrl_hold;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    dep_scoreboard #(.MAX_INFLIGHT(CAP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .issue_req(issue_req), .issue_kind(issue_kind),
        .issue_src_int(issue_src_int), .issue_src_fp(issue_src_fp),
        .issue_dst_int(issue_dst_int), .issue_dst_fp(issue_dst_fp),
        .issue_ok(issue_ok),
        .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
        .cmp_dst_int(cmp_dst_int), .cmp_dst_fp(cmp_dst_fp),
        .busy_int(busy_int), .busy_fp(busy_fp), .ctrl_hold(ctrl_hold)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        issue_req = 1'b0; issue_kind = 2'd0;
        issue_src_int = '0; issue_src_fp = '0; issue_dst_int = '0; issue_dst_fp = '0;
        cmp_valid = 1'b0; cmp_kind = 2'd0; cmp_dst_int = '0; cmp_dst_fp = '0;
    endtask

    task automatic req(input logic [1:0] k, input logic [31:0] si, input logic [31:0] sf,
                       input logic [31:0] di, input logic [31:0] df);
        issue_req = 1'b1; issue_kind = k;
        issue_src_int = si; issue_src_fp = sf; issue_dst_int = di; issue_dst_fp = df;
        #1;
    endtask

    task automatic done(input logic [1:0] k, input logic [31:0] di, input logic [31:0] df);
        cmp_valid = 1'b1; cmp_kind = k; cmp_dst_int = di; cmp_dst_fp = df;
        #1;
    endtask

    task automatic t_reset();
        check("R1 busy_int", busy_int, 0);
        check("R1 busy_fp", busy_fp, 0);
        check("R1 hold", ctrl_hold, 0);
        req(2'd0, 0, 0, 0, 0);
        check("R1 grant", issue_ok, 1);
        idle();
    endtask

    task automatic t_set_and_hazard();
        req(2'd0, 0, 0, 32'h21, 32'h8);
        check("R2 grant", issue_ok, 1);
        tick(); idle();
        check("R2 R3 busy_int", busy_int, 32'h20);
        check("R2 busy_fp", busy_fp, 32'h8);
        req(2'd0, 32'h20, 0, 0, 0);
        check("R4 int src busy", issue_ok, 0);
        req(2'd0, 0, 32'h8, 0, 0);
        check("R4 fp src busy", issue_ok, 0);
        req(2'd0, 32'h40, 32'h4, 0, 0);
        check("R4 src clear", issue_ok, 1);
        req(2'd0, 32'h20, 0, 32'h200, 32'h1);
        tick(); idle();
        check("R7 int unchanged", busy_int, 32'h20);
        check("R7 fp unchanged", busy_fp, 32'h8);
        done(2'd0, 32'h20, 32'h8);
        tick(); idle();
        check("R5 int cleared", busy_int, 0);
        check("R5 fp cleared", busy_fp, 0);
    endtask

    task automatic t_set_wins();
        req(2'd0, 0, 0, 32'h80, 0);
        tick(); idle();
        req(2'd0, 0, 0, 32'h80, 0);
        done(2'd0, 32'h80, 0);
        tick(); idle();
        check("R6 set wins", busy_int, 32'h80);
        done(2'd0, 32'h80, 0);
        tick(); idle();
        check("R5 final clear", busy_int, 0);
    endtask

    task automatic t_branch();
        req(2'd0, 0, 0, 32'h4, 0);
        tick(); idle();
        req(2'd1, 0, 0, 0, 0);
        check("R8 branch grant", issue_ok, 1);
        tick(); idle();
        check("R8 hold up", ctrl_hold, 1);
        req(2'd0, 0, 0, 0, 0);
        check("R8 plain blocked", issue_ok, 0);
        req(2'd1, 0, 0, 0, 0);
        check("R8 branch blocked", issue_ok, 0);
        idle();
        done(2'd0, 32'h4, 0);
        tick(); idle();
        req(2'd0, 0, 0, 0, 0);
        check("R8 still blocked", issue_ok, 0);
        idle();
        done(2'd1, 0, 0);
        tick(); idle();
        req(2'd0, 0, 0, 0, 0);
        check("R8 reopened", issue_ok, 1);
        idle();
    endtask

    task automatic t_window();
        req(2'd0, 0, 0, 32'h10, 0);
        tick(); idle();
        req(2'd2, 0, 0, 0, 0);
        check("R9 window refused", issue_ok, 0);
        tick(); idle();
        check("R9 drain hold", ctrl_hold, 1);
        req(2'd0, 0, 0, 0, 0);
        check("R9 plain blocked", issue_ok, 0);
        idle();
        done(2'd0, 32'h10, 0);
        tick(); idle();
        tick();
        check("R9 drain left", ctrl_hold, 0);
        req(2'd2, 0, 0, 32'h40000000, 0);
        check("R9 window granted", issue_ok, 1);
        tick(); idle();
        check("R10 hold up", ctrl_hold, 1);
        req(2'd0, 0, 0, 0, 0);
        check("R10 plain blocked", issue_ok, 0);
        idle();
        done(2'd2, 32'h40000000, 0);
        tick(); idle();
        check("R10 hold down", ctrl_hold, 0);
        req(2'd0, 0, 0, 0, 0);
        check("R10 reopened", issue_ok, 1);
        idle();
        check("R10 flags clear", busy_int, 0);
    endtask

    task automatic t_cap();
        int grants = 0;
        for (int i = 0; i < CAP; i++) begin
            req(2'd0, 0, 0, 0, 0);
            if (issue_ok) grants++;
            tick(); idle();
        end
        check("R11 grants to cap", grants, CAP);
        req(2'd0, 0, 0, 0, 0);
        check("R11 refused at cap", issue_ok, 0);
        idle();
        done(2'd0, 0, 0);
        tick(); idle();
        req(2'd0, 0, 0, 0, 0);
        check("R11 room again", issue_ok, 1);
        idle();
        for (int i = 0; i < CAP - 1; i++) begin
            done(2'd0, 0, 0);
            tick(); idle();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();
        t_reset();
        t_set_and_hazard();
        t_set_wins();
        t_branch();
        t_window();
        t_cap();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule